// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Bank

This block holds a bank of eight ownership flags that two independent agents, a left port and a right port, use to reserve resources they share. It stands apart from any shared storage. Each port has its own flag select, memory enable, write strobe, output enable, 3-bit flag address and 8-bit data buses. A port asks for a flag by writing 0 in bit 0 and gives it up, or withdraws its request, by writing 1. It polls by reading the flag: it reads 0 while it holds the flag and 1 otherwise.

Every flag keeps a request latch for each port. A request from the port that does not hold the flag is remembered. Ownership passes to that port in the same cycle in which the holder releases. When both ports ask for a free flag in the same clock cycle, the left port wins and the right port's request stays latched. Read results go into a register for each port, so a write from the opposite port cannot alter a value that is being returned. A bus-level tri-state is represented by a separate valid output.

Top module: `sem_bank_dp`

## Requirements
- R1: After reset, all eight flags are free with no latched requests, and both ports read 1 at every address. Both valid outputs are 0 while reset is applied.
- R2: A write with bit 0 = 0 to a free flag makes the writing port its holder. The holder then reads 0 there and the other port reads 1.
- R3: A write of 0 by the port that does not hold the flag only latches a request. The holder keeps the flag and keeps reading 0, and a port never loses a flag unless it made an access itself.
- R4: When the holder writes 1 while the other port has a latched request, the other port holds the flag from the next cycle on.
- R5: When the holder writes 1 with no request latched from the other side, the flag becomes free and both ports read 1.
- R6: A write of 1 by the port that does not hold the flag clears that port's latched request. A later release by the holder then frees the flag.
- R7: When both ports write 0 to the same free flag in the same cycle, the left port becomes holder and the right request stays latched.
- R8: Writes use only data bit 0. Bits 7..1 have no effect (0xFE requests, 0x01 releases).
- R9: A port accesses a flag only when its flag select is low and its memory enable is high. With both low (an illegal combination), or with only the memory enable low, no flag changes.
- R10: A read access is one with select low, memory enable high, write strobe high and output enable low. In the next cycle the valid output is 1 and all eight data bits carry the flag value: 0x00 if the port holds the flag, 0xFF if not.
- R11: A read returns the flag state from before any write that the other port makes in the same cycle.
- R12: The valid output is 0 in any cycle after a non-read access, including a read attempt with the output enable high.
- R13: The eight flags are independent. The address selects exactly one of them, and an access leaves the other seven unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| l_sem_n | input | 1 | Left flag select, active low |
| l_cen_n | input | 1 | Left memory enable, active low; must be high for flag access |
| l_we_n | input | 1 | Left write strobe, low = write, high = read |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 3 | Left flag address |
| l_wdata | input | 8 | Left write data; only bit 0 is used |
| l_rdata | output | 8 | Left registered read data |
| l_rvalid | output | 1 | Left read data valid (bus would be driven) |
| r_sem_n | input | 1 | Right flag select, active low |
| r_cen_n | input | 1 | Right memory enable, active low |
| r_we_n | input | 1 | Right write strobe |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 3 | Right flag address |
| r_wdata | input | 8 | Right write data; only bit 0 is used |
| r_rdata | output | 8 | Right registered read data |
| r_rvalid | output | 1 | Right read data valid |

## Verification
The bench targets handover. If the request latch were missing, the right port would still read 1 after the left port released its flag, because the flag would have gone free instead of passing to the waiting port. Same-cycle contention on a free flag is checked for a left win with the right request retained; a design without a fixed priority would give both ports 0 or neither. A read made in the same cycle as an opposite-port release must return the old value, which catches a read path taken from next state. Illegal enable combinations, set-high upper data bits and a read with the output enable high are all checked to change nothing.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;

  // Holder of a single flag
  typedef enum logic [1:0] {
    HOLD_NONE  = 2'd0,
    HOLD_LEFT  = 2'd1,
    HOLD_RIGHT = 2'd2
  } sem_holder_e;

endpackage

// File: rtl/sem_port_dec.sv
// Decodes one port's control pins into write strobes per flag and a read enable.
module sem_port_dec #(
  parameter int N_SEM = 8,
  localparam int AW = $clog2(N_SEM)
) (
  input  logic          sem_n,
  input  logic          cen_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  output logic [N_SEM-1:0] wr_hit,
  output logic          rd_en
);

  logic access;

  always_comb begin
    // flag access needs select low and memory enable high
    access = !sem_n && cen_n;
    rd_en  = access && we_n && !oe_n;
  end

  for (genvar i = 0; i < N_SEM; i++) begin : g_hit
    always_comb begin
      wr_hit[i] = access && !we_n && (addr == AW'(i));
    end
  end

endmodule

// File: rtl/sem_cell.sv
// One flag: holder state plus a request latch for each port.
module sem_cell
  import sem_bank_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic l_wr,
  input  logic l_bit,
  input  logic r_wr,
  input  logic r_bit,
  output logic held_l,
  output logic held_r
);

  sem_holder_e holder_q, holder_d;
  logic        req_l_q, req_l_d;
  logic        req_r_q, req_r_d;
  logic        upd;

  always_comb begin
    upd     = l_wr || r_wr;
    req_l_d = l_wr ? !l_bit : req_l_q;
    req_r_d = r_wr ? !r_bit : req_r_q;
    holder_d = holder_q;
    unique case (holder_q)
      HOLD_NONE: begin
        // left has priority on a same-cycle request
        if (req_l_d)      holder_d = HOLD_LEFT;
        else if (req_r_d) holder_d = HOLD_RIGHT;
      end
      HOLD_LEFT: begin
        if (!req_l_d) holder_d = req_r_d ? HOLD_RIGHT : HOLD_NONE;
      end
      HOLD_RIGHT: begin
        if (!req_r_d) holder_d = req_l_d ? HOLD_LEFT : HOLD_NONE;
      end
      default: holder_d = HOLD_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holder_q <= HOLD_NONE;
      req_l_q  <= 1'b0;
      req_r_q  <= 1'b0;
    end else if (upd) begin
      holder_q <= holder_d;
      req_l_q  <= req_l_d;
      req_r_q  <= req_r_d;
    end
  end

  always_comb begin
    held_l = (holder_q == HOLD_LEFT);
    held_r = (holder_q == HOLD_RIGHT);
  end

endmodule

// File: rtl/sem_rd_port.sv
// Registered read path of one port.
module sem_rd_port #(
  parameter int N_SEM = 8,
  parameter int DW    = 8,
  localparam int AW = $clog2(N_SEM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [N_SEM-1:0] held,
  output logic [DW-1:0]    rdata,
  output logic             rvalid
);

  logic [DW-1:0] data_q, data_d;
  logic          vld_q;

  always_comb begin
    data_d = {DW{!held[addr]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= {DW{1'b1}};
    end else if (rd_en) begin
      data_q <= data_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= rd_en;
  end

  assign rdata  = data_q;
  assign rvalid = vld_q;

endmodule

// File: rtl/sem_bank_dp.sv
module sem_bank_dp #(
  parameter int N_SEM = 8,
  parameter int DW    = 8,
  localparam int AW = $clog2(N_SEM)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_sem_n,
  input  logic          l_cen_n,
  input  logic          l_we_n,
  input  logic          l_oe_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_rvalid,
  input  logic          r_sem_n,
  input  logic          r_cen_n,
  input  logic          r_we_n,
  input  logic          r_oe_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_rvalid
);

  logic [N_SEM-1:0] l_hit, r_hit;
  logic             l_rd, r_rd;
  logic [N_SEM-1:0] held_l, held_r;

  sem_port_dec #(.N_SEM(N_SEM)) u_dec_l (
    .sem_n(l_sem_n), .cen_n(l_cen_n), .we_n(l_we_n), .oe_n(l_oe_n),
    .addr(l_addr), .wr_hit(l_hit), .rd_en(l_rd)
  );

  sem_port_dec #(.N_SEM(N_SEM)) u_dec_r (
    .sem_n(r_sem_n), .cen_n(r_cen_n), .we_n(r_we_n), .oe_n(r_oe_n),
    .addr(r_addr), .wr_hit(r_hit), .rd_en(r_rd)
  );

  for (genvar i = 0; i < N_SEM; i++) begin : g_flag
    sem_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .l_wr(l_hit[i]), .l_bit(l_wdata[0]),
      .r_wr(r_hit[i]), .r_bit(r_wdata[0]),
      .held_l(held_l[i]), .held_r(held_r[i])
    );
  end

  sem_rd_port #(.N_SEM(N_SEM), .DW(DW)) u_rd_l (
    .clk(clk), .rst_n(rst_n), .rd_en(l_rd), .addr(l_addr),
    .held(held_l), .rdata(l_rdata), .rvalid(l_rvalid)
  );

  sem_rd_port #(.N_SEM(N_SEM), .DW(DW)) u_rd_r (
    .clk(clk), .rst_n(rst_n), .rd_en(r_rd), .addr(r_addr),
    .held(held_r), .rdata(r_rdata), .rvalid(r_rvalid)
  );

endmodule

// File: rtl/sem_bank_dp_chk.sv
module sem_bank_dp_chk #(
  parameter int N_SEM = 8,
  parameter int DW    = 8,
  localparam int AW = $clog2(N_SEM)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             l_sem_n, l_cen_n, l_we_n, l_oe_n,
  input logic [AW-1:0]    l_addr,
  input logic [DW-1:0]    l_wdata, l_rdata,
  input logic             l_rvalid,
  input logic             r_sem_n, r_cen_n, r_we_n, r_oe_n,
  input logic [AW-1:0]    r_addr,
  input logic [DW-1:0]    r_wdata,
  input logic             r_rvalid,
  input logic [N_SEM-1:0] held_l, held_r
);

  logic l_acc, r_acc, l_req, r_req;
  assign l_acc = !l_sem_n && l_cen_n;
  assign r_acc = !r_sem_n && r_cen_n;
  assign l_req = l_acc && !l_we_n && !l_wdata[0];
  assign r_req = r_acc && !r_we_n && !r_wdata[0];

  // R12
  rvalid_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_rvalid |-> $past(l_acc && l_we_n && !l_oe_n));

  // R10
  rdata_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_rvalid |-> (l_rdata == {DW{1'b0}} || l_rdata == {DW{1'b1}}));

  // R9
  no_access_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_acc && !r_acc) |=> ($stable(held_l) && $stable(held_r)));

  // R3
  right_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !r_acc |=> ((~held_r & $past(held_r)) == '0));

  // R7
  left_wins_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_req && r_req && l_addr == r_addr && !held_l[l_addr] && !held_r[l_addr])
      |=> held_l[$past(l_addr)]);

endmodule

bind sem_bank_dp sem_bank_dp_chk #(.N_SEM(N_SEM), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_sem_n(l_sem_n), .l_cen_n(l_cen_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n),
  .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rvalid(l_rvalid),
  .r_sem_n(r_sem_n), .r_cen_n(r_cen_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n),
  .r_addr(r_addr), .r_wdata(r_wdata), .r_rvalid(r_rvalid),
  .held_l(held_l), .held_r(held_r)
);

// File: tb/test_sem_bank_dp.sv
module test_sem_bank_dp;

  logic clk = 1'b0;
  logic rst_n;
  logic l_sem_n, l_cen_n, l_we_n, l_oe_n;
  logic [2:0] l_addr;
  logic [7:0] l_wdata, l_rdata;
  logic l_rvalid;
  logic r_sem_n, r_cen_n, r_we_n, r_oe_n;
  logic [2:0] r_addr;
  logic [7:0] r_wdata, r_rdata;
  logic r_rvalid;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sem_bank_dp i_sem_bank_dp (
    .clk(clk), .rst_n(rst_n),
    .l_sem_n(l_sem_n), .l_cen_n(l_cen_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rvalid(l_rvalid),
    .r_sem_n(r_sem_n), .r_cen_n(r_cen_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rvalid(r_rvalid)
  );

  // op codes: 0 idle, 1 write, 2 read, 3 write with both enables low,
  //           4 read with output enable high, 5 write with memory enable only
  typedef struct packed {
    logic [2:0] lop; logic [2:0] la; logic [7:0] ld;
    logic [2:0] rop; logic [2:0] ra; logic [7:0] rd;
    logic lv; logic lb; logic rv; logic rb;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 38;
  localparam vec_t VEC [NV] = '{
    '{3'd2,3'd3,8'h00, 3'd0,3'd0,8'h00, 1,1,0,0, 4'd1},  // R1 free
    '{3'd0,3'd0,8'h00, 3'd2,3'd3,8'h00, 0,0,1,1, 4'd1},  // R1
    '{3'd1,3'd3,8'h00, 3'd0,3'd0,8'h00, 0,0,0,0, 4'd2},  // R2 left takes
    '{3'd2,3'd3,8'h00, 3'd2,3'd3,8'h00, 1,0,1,1, 4'd2},  // R2
    '{3'd0,3'd0,8'h00, 3'd1,3'd3,8'h00, 0,0,0,0, 4'd3},  // R3 right pends
    '{3'd2,3'd3,8'h00, 3'd2,3'd3,8'h00, 1,0,1,1, 4'd3},  // R3
    '{3'd1,3'd3,8'h01, 3'd0,3'd0,8'h00, 0,0,0,0, 4'd4},  // R4 hand over
    '{3'd2,3'd3,8'h00, 3'd2,3'd3,8'h00, 1,1,1,0, 4'd4},  // R4
    '{3'd0,3'd0,8'h00, 3'd1,3'd3,8'h01, 0,0,0,0, 4'd5},  // R5 free again
    '{3'd2,3'd3,8'h00, 3'd2,3'd3,8'h00, 1,1,1,1, 4'd5},  // R5
    '{3'd1,3'd3,8'h00, 3'd0,3'd0,8'h00, 0,0,0,0, 4'd6},  // R6
    '{3'd0,3'd0,8'h00, 3'd1,3'd3,8'h00, 0,0,0,0, 4'd6},  // R6 pend
    '{3'd0,3'd0,8'h00, 3'd1,3'd3,8'h01, 0,0,0,0, 4'd6},  // R6 cancel
    '{3'd1,3'd3,8'h01, 3'd0,3'd0,8'h00, 0,0,0,0, 4'd6},  // R6 release
    '{3'd2,3'd3,8'h00, 3'd2,3'd3,8'h00, 1,1,1,1, 4'd6},  // R6
    '{3'd1,3'd5,8'h00, 3'd1,3'd5,8'h00, 0,0,0,0, 4'd7},  // R7 tie
    '{3'd2,3'd5,8'h00, 3'd2,3'd5,8'h00, 1,0,1,1, 4'd7},  // R7
    '{3'd1,3'd5,8'h01, 3'd0,3'd0,8'h00, 0,0,0,0, 4'd7},  // R7
    '{3'd2,3'd5,8'h00, 3'd2,3'd5,8'h00, 1,1,1,0, 4'd7},  // R7 kept request
    '{3'd0,3'd0,8'h00, 3'd1,3'd5,8'h01, 0,0,0,0, 4'd7},  // R7
    '{3'd2,3'd5,8'h00, 3'd2,3'd5,8'h00, 1,1,1,1, 4'd7},  // R7
    '{3'd1,3'd2,8'hFE, 3'd0,3'd0,8'h00, 0,0,0,0, 4'd8},  // R8
    '{3'd2,3'd2,8'h00, 3'd2,3'd2,8'h00, 1,0,1,1, 4'd8},  // R8
    '{3'd1,3'd2,8'h01, 3'd0,3'd0,8'h00, 0,0,0,0, 4'd8},  // R8
    '{3'd2,3'd2,8'h00, 3'd0,3'd0,8'h00, 1,1,0,0, 4'd8},  // R8
    '{3'd3,3'd4,8'h00, 3'd5,3'd4,8'h00, 0,0,0,0, 4'd9},  // R9
    '{3'd2,3'd4,8'h00, 3'd2,3'd4,8'h00, 1,1,1,1, 4'd9},  // R9
    '{3'd4,3'd4,8'h00, 3'd4,3'd4,8'h00, 0,0,0,0, 4'd12}, // R12
    '{3'd1,3'd4,8'h00, 3'd0,3'd0,8'h00, 0,0,0,0, 4'd12}, // R12 write
    '{3'd0,3'd0,8'h00, 3'd1,3'd1,8'h00, 0,0,0,0, 4'd13}, // R13
    '{3'd2,3'd1,8'h00, 3'd2,3'd0,8'h00, 1,1,1,1, 4'd13}, // R13
    '{3'd2,3'd4,8'h00, 3'd2,3'd1,8'h00, 1,0,1,0, 4'd13}, // R13
    '{3'd1,3'd4,8'h01, 3'd1,3'd1,8'h01, 0,0,0,0, 4'd13}, // R13
    '{3'd1,3'd6,8'h00, 3'd0,3'd0,8'h00, 0,0,0,0, 4'd11}, // R11
    '{3'd0,3'd0,8'h00, 3'd1,3'd6,8'h00, 0,0,0,0, 4'd11}, // R11
    '{3'd1,3'd6,8'h01, 3'd2,3'd6,8'h00, 0,0,1,1, 4'd11}, // R11 old value
    '{3'd0,3'd0,8'h00, 3'd2,3'd6,8'h00, 0,0,1,0, 4'd11}, // R11 R10 now held
    '{3'd0,3'd0,8'h00, 3'd1,3'd6,8'h01, 0,0,0,0, 4'd10}  // R10 idle
  };

  // returns {sem_n, cen_n, we_n, oe_n}
  function automatic logic [3:0] pins(input logic [2:0] op);
    case (op)
      3'd1:    return 4'b0101;
      3'd2:    return 4'b0110;
      3'd3:    return 4'b0001;
      3'd4:    return 4'b0111;
      3'd5:    return 4'b1001;
      default: return 4'b1111;
    endcase
  endfunction

  task automatic drive(input logic [2:0] lo, input logic [2:0] la, input logic [7:0] ld,
                       input logic [2:0] ro, input logic [2:0] ra, input logic [7:0] rd);
    {l_sem_n, l_cen_n, l_we_n, l_oe_n} = pins(lo);
    {r_sem_n, r_cen_n, r_we_n, r_oe_n} = pins(ro);
    l_addr = la; l_wdata = ld; r_addr = ra; r_wdata = rd;
  endtask

  task automatic chk(input string side, input int req, input logic v, input logic [7:0] d,
                     input logic ev, input logic eb);
    n_chk++;
    if (v !== ev || (ev && d !== {8{eb}})) begin
      n_bad++;
      $display("FAIL R%0d %s: valid=%b data=%h expected valid=%b data=%h",
               req, side, v, d, ev, {8{eb}});
    end
  endtask

  task automatic step(input vec_t t);
    @(negedge clk);
    drive(t.lop, t.la, t.ld, t.rop, t.ra, t.rd);
    @(posedge clk);
    #1;
    chk("left", int'(t.req), l_rvalid, l_rdata, t.lv, t.lb);
    chk("right", int'(t.req), r_rvalid, r_rdata, t.rv, t.rb);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    drive(3'd0, 3'd0, 8'h00, 3'd0, 3'd0, 8'h00);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs quiet under reset
    chk("left", 1, l_rvalid, l_rdata, 1'b0, 1'b1);
    chk("right", 1, r_rvalid, r_rdata, 1'b0, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) step(VEC[k]);

    // R1: reset in mid-run frees a held flag and drops a latched request
    step('{3'd1,3'd0,8'h00, 3'd1,3'd0,8'h00, 0,0,0,0, 4'd1});
    @(negedge clk);
    drive(3'd0, 3'd0, 8'h00, 3'd0, 3'd0, 8'h00);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step('{3'd2,3'd0,8'h00, 3'd2,3'd0,8'h00, 1,1,1,1, 4'd1});
    // R1: left release must not hand over to a request cleared by reset
    step('{3'd1,3'd0,8'h01, 3'd0,3'd0,8'h00, 0,0,0,0, 4'd1});
    step('{3'd2,3'd0,8'h00, 3'd2,3'd0,8'h00, 1,1,1,1, 4'd1});
    // R10: valid lasts one cycle after a single read
    step('{3'd0,3'd0,8'h00, 3'd0,3'd0,8'h00, 0,0,0,0, 4'd10});

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule